// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the private data cache controller of one processor that shares a system bus with other masters. It holds a small direct-mapped array of one-word lines, each with a tag and a coherence state. Coherence follows the write-once invalidation scheme. The first store to a clean line goes through to memory, so that every other cache sees it on the bus and drops its own copy. Later stores to that line stay in the cache.

The processor side is a request port. A request is held until ready rises, and a load takes its data in that cycle. The block masters the shared bus for reads, write-throughs and flushes, and it waits for the memory's done pulse on each of them. A snoop port shows the block the address and kind (load or store) of each bus transaction issued by another master. When such a transaction hits a line that is modified here, the block aborts it in the same cycle, flushes the line, and leaves the other master to retry.

Top module: `wo_cache`

## Requirements
- R1: While reset is low, and until the first request after reset, cpu_ready, bus_valid and snp_abort are low and every line is Invalid, so the first access to any address misses.
- R2: A load miss issues a bus read (bus_cmd 1) at the load address. It raises cpu_ready in the cycle bus_done arrives, returns bus_rdata, and leaves the line Valid.
- R3: A load that hits a Valid, Reserved or Dirty line raises cpu_ready in the cycle of the request and returns the cached word. It issues no bus transaction.
- R4: A store that hits a Valid line issues a bus write (bus_cmd 2) carrying the store data. It raises cpu_ready with bus_done, updates the line and leaves it Reserved.
- R5: A store that hits a Reserved or Dirty line completes in the cycle of the request with no bus transaction. It updates the word and leaves the line Dirty.
- R6: A store miss issues a bus write (bus_cmd 2) of the store data at the store address. It then allocates the line with that data in the Reserved state.
- R7: A snooped load that hits a Valid line leaves it Valid, and one that hits a Reserved line demotes it to Valid. Neither raises snp_abort.
- R8: A snooped store that hits a Valid or Reserved line makes it Invalid without raising snp_abort. A snoop that misses changes nothing.
- R9: A snoop that hits a Dirty line raises snp_abort in that cycle. From the next cycle the block issues a flush (bus_cmd 3) of the line's word at its address. After bus_done the line becomes Valid for a snooped load and Invalid for a snooped store.
- R10: A miss whose victim line is Dirty first writes the victim back (bus_cmd 3, victim address and word) and only then reads or writes the new address. A clean victim is replaced with no write-back.
- R11: A cycle with snp_valid high in the idle state serves the snoop and holds cpu_ready low. cpu_ready is low while a bus transaction is outstanding, except in the cycle bus_done completes the processor's own read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_valid | output | 1 | Bus transaction outstanding |
| bus_cmd | output | 2 | 1 read, 2 write-through, 3 flush or write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data for commands 2 and 3 |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |
| bus_done | input | 1 | Memory completes the outstanding transaction |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_store | input | 1 | 1 = snooped store, 0 = snooped load |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | Abort the snooped transaction; retry later |

## Verification
Hits, and stores to Reserved or Dirty lines, complete in the same cycle as the request. Reads and write-throughs complete in the cycle bus_done arrives. A bus transaction starts in the cycle after the request or snoop that caused it, and snp_abort is combinational with the snoop. A new state is visible only from the next clock edge. The bench model follows these rules. Stimulus changes on the falling edge, and every output is compared with the model shortly after each falling edge, so both sides see the same settled inputs. The directed checks count completion cycles and bus transactions to tell hits from misses, write-through from local stores, and silent evictions from write-backs.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_VAL = 2'd1,
    LN_RSV = 2'd2,
    LN_DRT = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WRITE = 2'd2,
    BC_FLUSH = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_EVICT = 3'd1,
    CS_FILL  = 3'd2,
    CS_WRITE = 3'd3,
    CS_FLUSH = 3'd4
  } ctl_st_t;
endpackage

// File: rtl/wo_rst_sync.sv
module wo_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              st_we,
  input  line_st_t          wr_st,
  input  logic              dat_we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_all  [LINES];
  logic [TAG_W-1:0]  tag_all [LINES];
  logic [DATA_W-1:0] dat_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    logic              hit_w;

    assign hit_w = (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               st_r <= LN_INV;
      else if (st_we && hit_w)  st_r <= wr_st;
    end

    always_ff @(posedge clk) begin
      if (dat_we && hit_w) begin
        tag_r <= wr_tag;
        dat_r <= wr_data;
      end
    end

    assign st_all[g]  = st_r;
    assign tag_all[g] = tag_r;
    assign dat_all[g] = dat_r;
  end

  assign a_st   = st_all[a_idx];
  assign a_tag  = tag_all[a_idx];
  assign a_data = dat_all[a_idx];
  assign b_st   = st_all[b_idx];
  assign b_tag  = tag_all[b_idx];
endmodule

// File: rtl/wo_lookup.sv
module wo_lookup
  import wo_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  line_st_t         st,
  input  logic [TAG_W-1:0] held_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);
  assign hit = (st != LN_INV) && (held_tag == req_tag);
endmodule

// File: rtl/wo_ctrl.sv
module wo_ctrl
  import wo_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  input  logic              snp_valid,
  input  logic              snp_store,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_abort,
  output logic              bus_valid,
  output bus_cmd_t          bus_cmd,
  output logic [TAG_W+IDX_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  output logic [IDX_W-1:0]  a_idx,
  input  line_st_t          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              cpu_hit,
  input  line_st_t          b_st,
  input  logic              snp_hit,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              st_we,
  output line_st_t          wr_st,
  output logic              dat_we,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  ctl_st_t          cs_q, cs_d;
  logic [IDX_W-1:0] fl_idx_q;
  logic             fl_store_q;
  logic             fl_cap_en;

  always_comb begin
    cs_d      = cs_q;
    fl_cap_en = 1'b0;
    a_idx     = cpu_idx;
    cpu_ready = 1'b0;
    cpu_rdata = a_data;
    snp_abort = 1'b0;
    bus_valid = 1'b0;
    bus_cmd   = BC_NONE;
    bus_addr  = {cpu_tag, cpu_idx};
    bus_wdata = cpu_wdata;
    wr_idx    = cpu_idx;
    st_we     = 1'b0;
    wr_st     = LN_INV;
    dat_we    = 1'b0;
    wr_tag    = cpu_tag;
    wr_data   = cpu_wdata;
    case (cs_q)
      CS_IDLE: begin
        if (snp_valid) begin
          wr_idx = snp_idx;
          if (snp_hit) begin
            case (b_st)
              LN_VAL: begin
                st_we = snp_store;
                wr_st = LN_INV;
              end
              LN_RSV: begin
                st_we = 1'b1;
                wr_st = snp_store ? LN_INV : LN_VAL;
              end
              LN_DRT: begin
                snp_abort = 1'b1;
                fl_cap_en = 1'b1;
                cs_d      = CS_FLUSH;
              end
              default: ;
            endcase
          end
        end else if (cpu_req) begin
          if (cpu_hit && !cpu_we) begin
            cpu_ready = 1'b1;
          end else if (cpu_hit && a_st != LN_VAL) begin
            cpu_ready = 1'b1;
            st_we     = 1'b1;
            wr_st     = LN_DRT;
            dat_we    = 1'b1;
          end else if (cpu_hit) begin
            cs_d = CS_WRITE;
          end else if (a_st == LN_DRT) begin
            cs_d = CS_EVICT;
          end else begin
            cs_d = cpu_we ? CS_WRITE : CS_FILL;
          end
        end
      end
      CS_EVICT: begin
        bus_valid = 1'b1;
        bus_cmd   = BC_FLUSH;
        bus_addr  = {a_tag, cpu_idx};
        bus_wdata = a_data;
        if (bus_done) cs_d = cpu_we ? CS_WRITE : CS_FILL;
      end
      CS_FILL: begin
        bus_valid = 1'b1;
        bus_cmd   = BC_READ;
        cpu_rdata = bus_rdata;
        if (bus_done) begin
          cpu_ready = 1'b1;
          st_we     = 1'b1;
          wr_st     = LN_VAL;
          dat_we    = 1'b1;
          wr_data   = bus_rdata;
          cs_d      = CS_IDLE;
        end
      end
      CS_WRITE: begin
        bus_valid = 1'b1;
        bus_cmd   = BC_WRITE;
        if (bus_done) begin
          cpu_ready = 1'b1;
          st_we     = 1'b1;
          wr_st     = LN_RSV;
          dat_we    = 1'b1;
          cs_d      = CS_IDLE;
        end
      end
      CS_FLUSH: begin
        a_idx     = fl_idx_q;
        wr_idx    = fl_idx_q;
        bus_valid = 1'b1;
        bus_cmd   = BC_FLUSH;
        bus_addr  = {a_tag, fl_idx_q};
        bus_wdata = a_data;
        if (bus_done) begin
          st_we = 1'b1;
          wr_st = fl_store_q ? LN_INV : LN_VAL;
          cs_d  = CS_IDLE;
        end
      end
      default: cs_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= CS_IDLE;
    else        cs_q <= cs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_idx_q   <= '0;
      fl_store_q <= 1'b0;
    end else if (fl_cap_en) begin
      fl_idx_q   <= snp_idx;
      fl_store_q <= snp_store;
    end
  end
endmodule

// File: rtl/wo_cache.sv
module wo_cache
  import wo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              snp_valid,
  input  logic              snp_store,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rst_n_s;
  logic [IDX_W-1:0]  cpu_idx, snp_idx, a_idx, wr_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, wr_data;
  line_st_t          a_st, b_st, wr_st;
  logic              st_we, dat_we, cpu_hit, snp_hit;
  bus_cmd_t          cmd_w;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign bus_cmd = cmd_w;

  wo_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  wo_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n_s),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag),
    .wr_idx(wr_idx), .st_we(st_we), .wr_st(wr_st),
    .dat_we(dat_we), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wo_lookup #(.TAG_W(TAG_W)) u_cpu_lk (
    .st(a_st), .held_tag(a_tag), .req_tag(cpu_tag), .hit(cpu_hit)
  );

  wo_lookup #(.TAG_W(TAG_W)) u_snp_lk (
    .st(b_st), .held_tag(b_tag), .req_tag(snp_tag), .hit(snp_hit)
  );

  wo_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .snp_valid(snp_valid), .snp_store(snp_store), .snp_idx(snp_idx),
    .snp_abort(snp_abort),
    .bus_valid(bus_valid), .bus_cmd(cmd_w), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .cpu_hit(cpu_hit), .b_st(b_st), .snp_hit(snp_hit),
    .wr_idx(wr_idx), .st_we(st_we), .wr_st(wr_st), .dat_we(dat_we),
    .wr_tag(wr_tag), .wr_data(wr_data)
  );
endmodule

// File: rtl/wo_cache_chk.sv
module wo_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              bus_valid,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_done,
  input logic              snp_valid,
  input logic              snp_abort
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_quiet_in_reset_R1: assert (!cpu_ready && !bus_valid && !snp_abort)
        else $error("outputs active during reset");
    end
  end

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |-> !cpu_ready);

  assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !bus_valid) |-> !cpu_ready);

  assert_abort_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |=> (bus_valid && bus_cmd == 2'd3));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> !bus_valid);

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_cmd) && $stable(bus_addr)));
endmodule

bind wo_cache wo_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_valid(bus_valid),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_done(bus_done),
  .snp_valid(snp_valid), .snp_abort(snp_abort)
);

// File: tb/test_wo_cache.sv
`timescale 1ns/1ps
module test_wo_cache;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready;
  logic          bus_valid;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_done = 1'b0;
  logic          snp_valid = 1'b0, snp_store = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_abort;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  wo_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) i_wo_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .snp_valid(snp_valid), .snp_store(snp_store),
    .snp_addr(snp_addr), .snp_abort(snp_abort)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory: completes each transaction on the second cycle it is seen
  logic [DW-1:0] mem [256];
  int mcnt = 0, flush_cnt = 0, bus_ops = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = DW'(i * 7 + 3);

  always @(negedge clk) begin
    if (bus_done) begin
      bus_done <= 1'b0;
      mcnt = 0;
    end else if (bus_valid) begin
      mcnt++;
      if (mcnt == 2) begin
        bus_done  <= 1'b1;
        bus_rdata <= mem[bus_addr];
        bus_ops++;
        if (bus_cmd == 2'd3) flush_cnt++;
        if (bus_cmd != 2'd1) mem[bus_addr] = bus_wdata;
      end
    end
  end

  // reference model: 0 Invalid, 1 Valid, 2 Reserved, 3 Dirty
  int m_st [4], m_tag [4], m_dat [4];
  int ph = 0, f_idx = 0;
  bit f_store = 0;

  function automatic bit m_hit(input logic [AW-1:0] a);
    return m_st[a[1:0]] != 0 && m_tag[a[1:0]] == int'(a[7:2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_st[i] = 0;
      ph = 0;
    end else begin
      int ci, si;
      ci = int'(cpu_addr[1:0]);
      si = int'(snp_addr[1:0]);
      case (ph)
        0: begin
          if (snp_valid) begin
            if (m_hit(snp_addr)) begin
              if (m_st[si] == 1) begin
                if (snp_store) m_st[si] = 0;
              end else if (m_st[si] == 2) m_st[si] = snp_store ? 0 : 1;
              else begin
                ph = 4; f_idx = si; f_store = snp_store;
              end
            end
          end else if (cpu_req) begin
            if (m_hit(cpu_addr) && !cpu_we) ;
            else if (m_hit(cpu_addr) && m_st[ci] != 1) begin
              m_dat[ci] = int'(cpu_wdata); m_st[ci] = 3;
            end else if (m_hit(cpu_addr)) ph = 3;
            else ph = (m_st[ci] == 3) ? 1 : (cpu_we ? 3 : 2);
          end
        end
        1: if (bus_done) ph = cpu_we ? 3 : 2;
        2: if (bus_done) begin
             m_tag[ci] = int'(cpu_addr[7:2]); m_dat[ci] = int'(bus_rdata);
             m_st[ci] = 1; ph = 0;
           end
        3: if (bus_done) begin
             m_tag[ci] = int'(cpu_addr[7:2]); m_dat[ci] = int'(cpu_wdata);
             m_st[ci] = 2; ph = 0;
           end
        default: if (bus_done) begin
             m_st[f_idx] = f_store ? 0 : 1; ph = 0;
           end
      endcase
    end
  end

  // compare every cycle after the inputs have settled
  always @(negedge clk) begin
    #1;
    begin
      int ci;
      bit e_rdy, e_bv, e_ab;
      int e_cmd, e_addr, e_wd, e_rd;
      ci = int'(cpu_addr[1:0]);
      e_rdy = 0; e_bv = (ph != 0); e_ab = 0; e_cmd = 0; e_addr = 0; e_wd = 0;
      e_rd = m_dat[ci];
      if (!rst_n) ;
      else if (ph == 0) begin
        if (snp_valid) e_ab = m_hit(snp_addr) && m_st[int'(snp_addr[1:0])] == 3;
        else if (cpu_req && m_hit(cpu_addr) && (!cpu_we || m_st[ci] != 1)) e_rdy = 1;
      end else if (ph == 1) begin
        e_cmd = 3; e_addr = m_tag[ci] * 4 + ci; e_wd = m_dat[ci];
      end else if (ph == 2) begin
        e_cmd = 1; e_addr = int'(cpu_addr); e_rdy = bus_done; e_rd = int'(bus_rdata);
      end else if (ph == 3) begin
        e_cmd = 2; e_addr = int'(cpu_addr); e_wd = int'(cpu_wdata); e_rdy = bus_done;
      end else begin
        e_cmd = 3; e_addr = m_tag[f_idx] * 4 + f_idx; e_wd = m_dat[f_idx];
      end
      check(cpu_ready == e_rdy, cur_req, "cpu_ready", int'(cpu_ready), int'(e_rdy));
      check(bus_valid == e_bv, cur_req, "bus_valid", int'(bus_valid), int'(e_bv));
      check(snp_abort == e_ab, cur_req, "snp_abort", int'(snp_abort), int'(e_ab));
      if (e_bv && bus_valid) begin
        check(int'(bus_cmd) == e_cmd, cur_req, "bus_cmd", int'(bus_cmd), e_cmd);
        check(int'(bus_addr) == e_addr, cur_req, "bus_addr", int'(bus_addr), e_addr);
        if (e_cmd != 1)
          check(int'(bus_wdata) == e_wd, cur_req, "bus_wdata", int'(bus_wdata), e_wd);
      end
      if (e_rdy && cpu_ready && !cpu_we)
        check(int'(cpu_rdata) == e_rd, cur_req, "cpu_rdata", int'(cpu_rdata), e_rd);
    end
  end

  int last_cyc;
  logic [DW-1:0] last_rd;

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    last_cyc = 0;
    for (int n = 0; n < 40; n++) begin
      bit got;
      #1;
      got = cpu_ready; last_rd = cpu_rdata; last_cyc++;
      @(negedge clk);
      if (got) break;
    end
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic snoop(input bit st, input logic [AW-1:0] a, output bit ab);
    @(negedge clk);
    snp_valid = 1; snp_store = st; snp_addr = a;
    #1 ab = snp_abort;
    @(negedge clk);
    snp_valid = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    if (1) begin
      check(!cpu_ready && !bus_valid && !snp_abort, "R1", "outputs in reset",
            int'({cpu_ready, bus_valid, snp_abort}), 0);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
  end

  initial begin
    bit ab;
    int ops, fl;
    repeat (10) @(negedge clk);
    cur_req = "R2";
    cpu_op(0, 8'h05, '0);
    check(last_cyc > 1, "R1", "first access misses", last_cyc, 2);
    check(last_rd == DW'(8'h05 * 7 + 3), "R2", "fill data", int'(last_rd), 8'h05 * 7 + 3);
    cur_req = "R3";
    cpu_op(0, 8'h05, '0);
    check(last_cyc == 1, "R3", "load hit cycles", last_cyc, 1);
    cur_req = "R4";
    cpu_op(1, 8'h05, 16'hA1A1);
    check(last_cyc > 1 && mem[8'h05] == 16'hA1A1, "R4", "write-through", int'(mem[8'h05]), 16'hA1A1);
    cur_req = "R5";
    cpu_op(1, 8'h05, 16'hB2B2);
    check(last_cyc == 1 && mem[8'h05] == 16'hA1A1, "R5", "reserved store local", last_cyc, 1);
    cpu_op(1, 8'h05, 16'hC3C3);
    check(last_cyc == 1, "R5", "dirty store local", last_cyc, 1);
    cur_req = "R3";
    cpu_op(0, 8'h05, '0);
    check(last_rd == 16'hC3C3, "R3", "dirty load hit", int'(last_rd), 16'hC3C3);
    cur_req = "R9";
    snoop(0, 8'h05, ab);
    check(ab, "R9", "abort on dirty", int'(ab), 1);
    check(mem[8'h05] == 16'hC3C3, "R9", "flushed word", int'(mem[8'h05]), 16'hC3C3);
    cpu_op(0, 8'h05, '0);
    check(last_cyc == 1, "R9", "line kept valid", last_cyc, 1);
    cur_req = "R7";
    cpu_op(1, 8'h05, 16'hD4D4);
    snoop(0, 8'h05, ab);
    check(!ab, "R7", "no abort on reserved", int'(ab), 0);
    cpu_op(1, 8'h05, 16'hE5E5);
    check(last_cyc > 1 && mem[8'h05] == 16'hE5E5, "R7", "demoted to valid", last_cyc, 2);
    snoop(0, 8'h05, ab);
    cpu_op(0, 8'h05, '0);
    check(last_cyc == 1 && !ab, "R7", "valid stays valid", last_cyc, 1);
    cur_req = "R8";
    snoop(1, 8'h05, ab);
    check(!ab, "R8", "no abort on valid", int'(ab), 0);
    cpu_op(0, 8'h05, '0);
    check(last_cyc > 1, "R8", "invalidated", last_cyc, 2);
    cur_req = "R6";
    cpu_op(1, 8'h0A, 16'hF6F6);
    check(last_cyc > 1 && mem[8'h0A] == 16'hF6F6, "R6", "store miss written", int'(mem[8'h0A]), 16'hF6F6);
    cpu_op(1, 8'h0A, 16'h1717);
    check(last_cyc == 1 && mem[8'h0A] == 16'hF6F6, "R6", "allocated reserved", last_cyc, 1);
    cur_req = "R10";
    cpu_op(0, 8'h0E, '0);
    check(mem[8'h0A] == 16'h1717, "R10", "dirty victim written back", int'(mem[8'h0A]), 16'h1717);
    check(last_rd == DW'(8'h0E * 7 + 3), "R10", "new line data", int'(last_rd), 8'h0E * 7 + 3);
    fl = flush_cnt;
    cpu_op(0, 8'h11, '0);
    check(flush_cnt == fl, "R10", "clean victim silent", flush_cnt, fl);
    cur_req = "R9";
    cpu_op(1, 8'h0E, 16'h2828);
    cpu_op(1, 8'h0E, 16'h3939);
    snoop(1, 8'h0E, ab);
    check(ab && mem[8'h0E] == 16'h3939, "R9", "flush before invalidate", int'(mem[8'h0E]), 16'h3939);
    cpu_op(0, 8'h0E, '0);
    check(last_cyc > 1, "R9", "invalid after store snoop", last_cyc, 2);
    cur_req = "R11";
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h11;
    snp_valid = 1; snp_store = 1; snp_addr = 8'h22;
    #1 check(!cpu_ready, "R11", "snoop cycle blocks cpu", int'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 0;
    #1 check(cpu_ready, "R11", "served after snoop", int'(cpu_ready), 1);
    @(negedge clk);
    cpu_req = 0;
    cur_req = "R8";
    ops = bus_ops;
    snoop(1, 8'h31, ab);
    cpu_op(0, 8'h11, '0);
    check(last_cyc == 1 && bus_ops == ops, "R8", "snoop miss no effect", last_cyc, 1);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule